// File: doc/BRIEF.md
# Weekly Alarm Matcher

This block holds an alarm setting and watches the running time of a calendar counter that sits beside it. The setting is a BCD minute, a BCD hour and a seven-bit weekday mask. At each second tick that lands on second zero, the block compares the current minute, hour and weekday with the setting. A full match sets a sticky pending flag, but only while the alarm is enabled. The interrupt output is the pending flag gated by the enable bit.

The weekday is given as a mask instead of a date. One setting can therefore fire on several days of the week, and the alarm never reaches further than one week ahead. The resolution is one minute. Each field of the setting has its own write strobe, so the setting can be changed without touching the enable bit. Software clears the pending flag with a one-cycle clear pulse.

Top module: `alarm_matcher`

## Requirements
- R1: A synchronous reset clears the alarm enable, the pending flag, the weekday mask (to all zeros), the alarm minute and the alarm hour. `irq` is low in the cycle after reset.
- R2: The pending flag is set when all of these hold in the same cycle: `tick_i` is high, `now_sec_i` is 0x00, `now_min_i` equals the alarm minute, `now_hour_i` equals the alarm hour, the mask bit for `now_wday_i` is set, and the alarm is enabled. `irq` goes high in the cycle after that edge.
- R3: If the minute or the hour differs from the setting, the flag is not set.
- R4: Mask bit n (bit 0 is the least significant) selects weekday code n, for n from 0 to 6. With several bits set, the alarm fires on each selected day and on no other day. Weekday code 7 never matches.
- R5: A tick with a nonzero second value never sets the flag. Matching time values without a tick never set the flag.
- R6: A weekday mask of all zeros never matches, even while the alarm is enabled.
- R7: While the alarm is disabled, a match does not set the flag. Enabling the alarm later does not raise `irq` for that earlier match.
- R8: The flag is sticky. Once set, it stays set with no further match until a cycle with `irq_clr_i` high, and it reads clear from the next cycle.
- R9: If a match and `irq_clr_i` occur in the same cycle, the set wins and the flag stays set.
- R10: `irq` is the pending flag ANDed with the enable. Disabling the alarm while the flag is set lowers `irq`. Enabling it again raises `irq` with no new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_min_we_i | input | 1 | Write strobe for the alarm minute |
| set_min_i | input | 7 | Alarm minute, BCD |
| set_hour_we_i | input | 1 | Write strobe for the alarm hour |
| set_hour_i | input | 6 | Alarm hour, BCD, 24-hour |
| set_wmask_we_i | input | 1 | Write strobe for the weekday mask |
| set_wmask_i | input | 7 | Weekday mask; bit n selects weekday n |
| set_en_we_i | input | 1 | Write strobe for the enable bit |
| set_en_i | input | 1 | Alarm enable value |
| irq_clr_i | input | 1 | Clears the pending flag (write one to clear) |
| tick_i | input | 1 | One-cycle pulse at each second update |
| now_sec_i | input | 7 | Current second, BCD |
| now_min_i | input | 7 | Current minute, BCD |
| now_hour_i | input | 6 | Current hour, BCD |
| now_wday_i | input | 3 | Current weekday code, 0 to 6 |
| irq | output | 1 | Alarm interrupt |

## Verification
The stored setting, the enable and the pending flag can only be seen through `irq`. Each can be probed with a chosen tick followed by a check one cycle later. A corrupted minute, hour or mask bit shows up on the next tick that ought to match: `irq` either stays low or rises on the wrong day. A wrong flag or enable shows up at once, because `irq` follows them combinationally. Toggling the enable while the flag is pending exposes the flag on its own, with no new match needed.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int SEC_W  = 7;
    localparam int NDAYS  = 7;
    localparam int WDAY_W = $clog2(NDAYS + 1);

    typedef struct packed {
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [NDAYS-1:0]  wmask;
    } alm_cfg_t;

    typedef struct packed {
        logic              tick;
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [WDAY_W-1:0] wday;
    } now_t;

    // True when the weekday code is in range and selected by the mask.
    function automatic logic day_selected(input logic [NDAYS-1:0] mask,
                                          input logic [WDAY_W-1:0] wday);
        logic sel;
        sel = 1'b0;
        for (int i = 0; i < NDAYS; i++) begin
            if (wday == WDAY_W'(i) && mask[i]) sel = 1'b1;
        end
        return sel;
    endfunction
endpackage

// File: rtl/alm_cfg_regs.sv
module alm_cfg_regs
    import alarm_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              min_we,
    input  logic [MIN_W-1:0]  min_d,
    input  logic              hour_we,
    input  logic [HOUR_W-1:0] hour_d,
    input  logic              wmask_we,
    input  logic [NDAYS-1:0]  wmask_d,
    input  logic              en_we,
    input  logic              en_d,
    output alm_cfg_t          cfg_q,
    output logic              en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (min_we)   cfg_q.min   <= min_d;
            if (hour_we)  cfg_q.hour  <= hour_d;
            if (wmask_we) cfg_q.wmask <= wmask_d;
            if (en_we)    en_q        <= en_d;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!en_q && cfg_q.wmask == '0));
endmodule

// File: rtl/alm_compare.sv
module alm_compare
    import alarm_match_pkg::*;
(
    input  alm_cfg_t cfg,
    input  now_t     now,
    output logic     hit
);
    logic on_minute;
    logic time_eq;
    logic day_ok;

    always_comb begin
        on_minute = now.tick && (now.sec == '0);
        time_eq   = (now.min == cfg.min) && (now.hour == cfg.hour);
        day_ok    = day_selected(cfg.wmask, now.wday);
        hit       = on_minute && time_eq && day_ok;
    end
endmodule

// File: rtl/alm_sticky_flag.sv
module alm_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q);
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
    import alarm_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_min_we_i,
    input  logic [MIN_W-1:0]  set_min_i,
    input  logic              set_hour_we_i,
    input  logic [HOUR_W-1:0] set_hour_i,
    input  logic              set_wmask_we_i,
    input  logic [NDAYS-1:0]  set_wmask_i,
    input  logic              set_en_we_i,
    input  logic              set_en_i,
    input  logic              irq_clr_i,
    input  logic              tick_i,
    input  logic [SEC_W-1:0]  now_sec_i,
    input  logic [MIN_W-1:0]  now_min_i,
    input  logic [HOUR_W-1:0] now_hour_i,
    input  logic [WDAY_W-1:0] now_wday_i,
    output logic              irq
);
    alm_cfg_t cfg;
    now_t     now;
    logic     en;
    logic     hit;
    logic     pend;

    assign now = '{tick: tick_i, sec: now_sec_i, min: now_min_i,
                   hour: now_hour_i, wday: now_wday_i};

    alm_cfg_regs u_regs (
        .clk(clk), .rst(rst),
        .min_we(set_min_we_i), .min_d(set_min_i),
        .hour_we(set_hour_we_i), .hour_d(set_hour_i),
        .wmask_we(set_wmask_we_i), .wmask_d(set_wmask_i),
        .en_we(set_en_we_i), .en_d(set_en_i),
        .cfg_q(cfg), .en_q(en)
    );

    alm_compare u_cmp (.cfg(cfg), .now(now), .hit(hit));

    alm_sticky_flag u_flag (
        .clk(clk), .rst(rst),
        .set_i(hit && en), .clr_i(irq_clr_i), .flag_q(pend)
    );

    assign irq = pend & en;

    a_r5_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(tick_i && now_sec_i == '0));
    a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(en));
    a_r6_zero_mask_no_hit: assert property (@(posedge clk) disable iff (rst)
        (cfg.wmask == '0) |-> !hit);
    a_r3_hit_needs_time: assert property (@(posedge clk) disable iff (rst)
        hit |-> (now_min_i == cfg.min && now_hour_i == cfg.hour));
endmodule

// File: tb/alarm_matcher_tb.sv
module alarm_matcher_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       min_we = 0, hour_we = 0, mask_we = 0, en_we = 0, en_d = 0;
    logic [6:0] min_d = 0;
    logic [5:0] hour_d = 0;
    logic [6:0] mask_d = 0;
    logic       clr = 0, tick = 0;
    logic [6:0] sec = 0, nmin = 0;
    logic [5:0] nhour = 0;
    logic [2:0] wday = 0;
    logic       irq;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    alarm_matcher u_dut (
        .clk(clk), .rst(rst),
        .set_min_we_i(min_we), .set_min_i(min_d),
        .set_hour_we_i(hour_we), .set_hour_i(hour_d),
        .set_wmask_we_i(mask_we), .set_wmask_i(mask_d),
        .set_en_we_i(en_we), .set_en_i(en_d),
        .irq_clr_i(clr), .tick_i(tick),
        .now_sec_i(sec), .now_min_i(nmin), .now_hour_i(nhour), .now_wday_i(wday),
        .irq(irq)
    );

    task automatic chk(input logic exp, input string req);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s: irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] m, input logic [5:0] h,
                             input logic [6:0] mk, input logic e);
        @(negedge clk);
        min_we = 1; hour_we = 1; mask_we = 1; en_we = 1;
        min_d = m; hour_d = h; mask_d = mk; en_d = e;
        @(negedge clk);
        min_we = 0; hour_we = 0; mask_we = 0; en_we = 0;
    endtask

    task automatic set_en(input logic e);
        @(negedge clk); en_we = 1; en_d = e;
        @(negedge clk); en_we = 0;
    endtask

    task automatic clear_irq();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    // Drive one cycle of time inputs; irq is sampled one cycle later.
    task automatic step(input logic t, input logic [6:0] s, input logic [6:0] m,
                        input logic [5:0] h, input logic [2:0] d, input logic c);
        @(negedge clk);
        tick = t; sec = s; nmin = m; nhour = h; wday = d; clr = c;
        @(negedge clk);
        tick = 0; clr = 0;
    endtask

    task automatic t_reset();
        chk(1'b0, "R1 irq low after reset");
        set_en(1'b1);
        step(1, 7'h00, 7'h00, 6'h00, 3'd0, 0);
        chk(1'b0, "R1 mask reset to zero");
        set_en(1'b0);
    endtask

    task automatic t_basic();
        cfg_write(7'h30, 6'h12, 7'b0001000, 1'b1);
        step(1, 7'h00, 7'h30, 6'h12, 3'd3, 0);
        chk(1'b1, "R2 full match fires");
        repeat (5) @(negedge clk);
        chk(1'b1, "R8 flag sticky");
        clear_irq();
        chk(1'b0, "R8 clear pulse");
    endtask

    task automatic t_mismatch();
        step(1, 7'h00, 7'h31, 6'h12, 3'd3, 0);
        chk(1'b0, "R3 minute mismatch");
        step(1, 7'h00, 7'h30, 6'h13, 3'd3, 0);
        chk(1'b0, "R3 hour mismatch");
        step(1, 7'h00, 7'h30, 6'h12, 3'd2, 0);
        chk(1'b0, "R4 weekday not selected");
    endtask

    task automatic t_seconds();
        step(1, 7'h01, 7'h30, 6'h12, 3'd3, 0);
        chk(1'b0, "R5 nonzero second");
        step(0, 7'h00, 7'h30, 6'h12, 3'd3, 0);
        chk(1'b0, "R5 no tick");
    endtask

    task automatic t_multi();
        cfg_write(7'h05, 6'h07, 7'b1000101, 1'b1);
        step(1, 7'h00, 7'h05, 6'h07, 3'd0, 0);
        chk(1'b1, "R4 day 0 selected");
        clear_irq();
        step(1, 7'h00, 7'h05, 6'h07, 3'd2, 0);
        chk(1'b1, "R4 day 2 selected");
        clear_irq();
        step(1, 7'h00, 7'h05, 6'h07, 3'd6, 0);
        chk(1'b1, "R4 day 6 selected");
        clear_irq();
        step(1, 7'h00, 7'h05, 6'h07, 3'd1, 0);
        chk(1'b0, "R4 day 1 not selected");
        step(1, 7'h00, 7'h05, 6'h07, 3'd7, 0);
        chk(1'b0, "R4 code 7 never matches");
    endtask

    task automatic t_zero_mask();
        cfg_write(7'h05, 6'h07, 7'b0000000, 1'b1);
        for (int d = 0; d < 7; d++) begin
            step(1, 7'h00, 7'h05, 6'h07, 3'(d), 0);
            chk(1'b0, "R6 zero mask");
        end
    endtask

    task automatic t_disabled();
        cfg_write(7'h59, 6'h23, 7'b0010000, 1'b0);
        step(1, 7'h00, 7'h59, 6'h23, 3'd4, 0);
        chk(1'b0, "R7 disabled no irq");
        set_en(1'b1);
        chk(1'b0, "R7 no stale flag on enable");
    endtask

    task automatic t_gate();
        step(1, 7'h00, 7'h59, 6'h23, 3'd4, 0);
        chk(1'b1, "R10 fires enabled");
        set_en(1'b0);
        chk(1'b0, "R10 disable masks irq");
        set_en(1'b1);
        chk(1'b1, "R10 re-enable shows pending");
        clear_irq();
        chk(1'b0, "R8 cleared");
    endtask

    task automatic t_setclr();
        step(1, 7'h00, 7'h59, 6'h23, 3'd4, 1);
        chk(1'b1, "R9 set beats clear from idle");
        step(1, 7'h00, 7'h59, 6'h23, 3'd4, 1);
        chk(1'b1, "R9 set beats clear while pending");
        clear_irq();
        chk(1'b0, "R8 final clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_seconds();
        t_multi();
        t_zero_mask();
        t_disabled();
        t_gate();
        t_setclr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule